// File: doc/BRIEF.md
# Memory bank address decoder

This block holds the bank configuration of a memory controller in two 32-bit configuration registers. Each register carries two 16-bit bank fields. From each field the block derives a valid flag, a base address and a bank size. All three are presented continuously on its outputs.

Every cycle the block compares a physical request address against all valid banks. One clock edge later it reports whether a bank was hit, which bank it was, and whether more than one bank claimed the address.

A revision input chooses between two address granularities. Revisions at or above a threshold (default 5) use the coarse one; older revisions use the fine one. Configuration registers are loaded from a plain write port that carries a register select and a 32-bit data word.

Top module: `mem_bank_decoder`

## Requirements
- R1: While reset is held, and after it is released, both configuration registers are zero. All four bankValid bits read 0, and hit, bankIdx and overlap read 0.
- R2: A write with wrSel=0 loads banks 0 and 1, and a write with wrSel=1 loads banks 2 and 3. Bits 31:16 of the word hold the even bank and bits 15:0 hold the odd bank. The new values are visible on the per-bank outputs after the write's clock edge, and bank b's outputs occupy slice b of each flattened bus.
- R3: Bit 13 of a field is the bank's valid flag and drives bankValid[b]. A bank with the flag clear never produces a hit.
- R4: bankBase is the field's bits 7:0 shifted left by 24 when revId is 5 or more, and shifted left by 22 when revId is below 5.
- R5: bankSize is the field's bits 12:8 placed at bit 8, plus 0x100. The sum is shifted left by 16 when revId is 5 or more, and by 14 when revId is below 5.
- R6: A bank matches when it is valid and base <= reqAddr < base + size. The upper bound is computed with 33-bit arithmetic, so a bank whose end lies past 2^32 does not wrap around to low addresses. On a miss, bankIdx is 0.
- R7: When several banks match, bankIdx names the lowest-numbered one and overlap is 1. Overlap is 0 when at most one bank matches.
- R8: hit, bankIdx and overlap are registered. They reflect the reqAddr, revId and configuration present at the preceding rising clock edge.
- R9: Bits 15:14 of each field have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Configuration write strobe |
| wrSel | input | 1 | Configuration register select (0 or 1) |
| wrData | input | 32 | Configuration write data |
| revId | input | 4 | Chip revision; selects the address granularity |
| reqAddr | input | 32 | Physical address to decode |
| bankValid | output | 4 | Valid flag per bank, bit b for bank b |
| bankBase | output | 128 | Base address per bank, bank b in bits 32b+31:32b |
| bankSize | output | 128 | Size per bank, bank b in bits 32b+31:32b |
| hit | output | 1 | Registered: some valid bank holds the address |
| bankIdx | output | 2 | Registered: index of the winning bank |
| overlap | output | 1 | Registered: more than one bank matched |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 4-bit revision with threshold 5, an 8-bit base field and a 5-bit size mask. With these values both granularities are reachable by varying revId alone.

The default widths also let one bank reach past 2^32 (base 0xFF000000, size 0x20000000). This makes the no-wrap rule testable with a real address. A chosen configuration makes bank 2 sit inside bank 1, so the priority and overlap paths are exercised. Bank 3 is left invalid, so it is checked that an invalid bank never claims an address.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int CFG_REGS  = 2;
  localparam int BANKS     = 2 * CFG_REGS;
  localparam int IDX_W     = $clog2(BANKS);
  localparam int FIELD_W   = 16;
  localparam int REG_W     = 2 * FIELD_W;

  typedef struct packed {
    logic [CFG_REGS-1:0] load;
    logic                wideGran;
  } mbdStrobe_t;
endpackage

// File: rtl/mbd_ctrl.sv
module mbd_ctrl
  import mbd_pkg::*;
#(
  parameter int REV_W      = 4,
  parameter int REV_THRESH = 5
) (
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [REV_W-1:0] revId,
  output mbdStrobe_t       strobe
);
  always_comb begin
    strobe = '0;
    for (int r = 0; r < CFG_REGS; r++) begin
      strobe.load[r] = wrEn && (wrSel == r[0]);
    end
    strobe.wideGran = (revId >= REV_W'(REV_THRESH));
  end
endmodule

// File: rtl/mbd_bank_dec.sv
module mbd_bank_dec #(
  parameter int ADDR_W    = 32,
  parameter int BASE_W    = 8,
  parameter int MASK_W    = 5,
  parameter int BASE_SH_W = 24,
  parameter int BASE_SH_N = 22,
  parameter int SIZE_SH_W = 16,
  parameter int SIZE_SH_N = 14,
  localparam int USED_W   = BASE_W + MASK_W + 1,
  localparam int SU_W     = BASE_W + MASK_W + 1
) (
  input  logic [USED_W-1:0] field,
  input  logic              wideGran,
  input  logic [ADDR_W-1:0] addr,
  output logic              valid,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] size,
  output logic              match
);
  logic [BASE_W-1:0] baseField;
  logic [MASK_W-1:0] maskField;
  logic [SU_W-1:0]   sizeUnit;
  logic [ADDR_W:0]   endAddr;

  assign valid     = field[USED_W-1];
  assign baseField = field[BASE_W-1:0];
  assign maskField = field[BASE_W +: MASK_W];
  assign sizeUnit  = SU_W'({maskField, {BASE_W{1'b0}}}) + (SU_W'(1) << BASE_W);

  always_comb begin
    if (wideGran) begin
      base = ADDR_W'(baseField) << BASE_SH_W;
      size = ADDR_W'(sizeUnit) << SIZE_SH_W;
    end else begin
      base = ADDR_W'(baseField) << BASE_SH_N;
      size = ADDR_W'(sizeUnit) << SIZE_SH_N;
    end
  end

  assign endAddr = {1'b0, base} + {1'b0, size};
  assign match   = valid && (addr >= base) && ({1'b0, addr} < endAddr);
endmodule

// File: rtl/mbd_dpath.sv
module mbd_dpath
  import mbd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BASE_W    = 8,
  parameter int MASK_W    = 5,
  parameter int BASE_SH_W = 24,
  parameter int BASE_SH_N = 22,
  parameter int SIZE_SH_W = 16,
  parameter int SIZE_SH_N = 14,
  localparam int USED_W   = BASE_W + MASK_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mbdStrobe_t               strobe,
  input  logic [REG_W-1:0]         wrData,
  input  logic [ADDR_W-1:0]        reqAddr,
  output logic [BANKS-1:0]         bankValid,
  output logic [BANKS*ADDR_W-1:0]  bankBase,
  output logic [BANKS*ADDR_W-1:0]  bankSize,
  output logic                     hit,
  output logic [IDX_W-1:0]         bankIdx,
  output logic                     overlap
);
  logic [USED_W-1:0] fieldQ [BANKS];
  logic [BANKS-1:0]  bankMatch;
  logic              unusedWrBits;

  // even bank in the upper half, odd bank in the lower half
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < BANKS; b++) fieldQ[b] <= '0;
    end else begin
      for (int r = 0; r < CFG_REGS; r++) begin
        if (strobe.load[r]) begin
          fieldQ[2*r]   <= wrData[FIELD_W +: USED_W];
          fieldQ[2*r+1] <= wrData[0 +: USED_W];
        end
      end
    end
  end

  always_comb begin
    unusedWrBits = 1'b0;
    for (int h = 0; h < 2; h++) begin
      for (int k = USED_W; k < FIELD_W; k++) begin
        unusedWrBits = unusedWrBits ^ wrData[h*FIELD_W + k];
      end
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    mbd_bank_dec #(
      .ADDR_W(ADDR_W), .BASE_W(BASE_W), .MASK_W(MASK_W),
      .BASE_SH_W(BASE_SH_W), .BASE_SH_N(BASE_SH_N),
      .SIZE_SH_W(SIZE_SH_W), .SIZE_SH_N(SIZE_SH_N)
    ) u_dec (
      .field   (fieldQ[b]),
      .wideGran(strobe.wideGran),
      .addr    (reqAddr),
      .valid   (bankValid[b]),
      .base    (bankBase[b*ADDR_W +: ADDR_W]),
      .size    (bankSize[b*ADDR_W +: ADDR_W]),
      .match   (bankMatch[b])
    );
  end

  logic [IDX_W-1:0] selIdx;
  logic [IDX_W:0]   matchCnt;

  always_comb begin
    selIdx   = '0;
    matchCnt = '0;
    for (int b = BANKS - 1; b >= 0; b--) begin
      if (bankMatch[b]) begin
        selIdx   = IDX_W'(b);
        matchCnt = matchCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hit     <= 1'b0;
      bankIdx <= '0;
      overlap <= 1'b0;
    end else begin
      hit     <= |bankMatch;
      bankIdx <= selIdx;
      overlap <= (matchCnt > 1);
    end
  end
endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder
  import mbd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REV_W      = 4,
  parameter int REV_THRESH = 5,
  parameter int BASE_W     = 8,
  parameter int MASK_W     = 5,
  parameter int BASE_SH_W  = 24,
  parameter int BASE_SH_N  = 22,
  parameter int SIZE_SH_W  = 16,
  parameter int SIZE_SH_N  = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     wrSel,
  input  logic [REG_W-1:0]         wrData,
  input  logic [REV_W-1:0]         revId,
  input  logic [ADDR_W-1:0]        reqAddr,
  output logic [BANKS-1:0]         bankValid,
  output logic [BANKS*ADDR_W-1:0]  bankBase,
  output logic [BANKS*ADDR_W-1:0]  bankSize,
  output logic                     hit,
  output logic [IDX_W-1:0]         bankIdx,
  output logic                     overlap
);
  mbdStrobe_t strobe;

  mbd_ctrl #(.REV_W(REV_W), .REV_THRESH(REV_THRESH)) u_ctrl (
    .wrEn  (wrEn),
    .wrSel (wrSel),
    .revId (revId),
    .strobe(strobe)
  );

  mbd_dpath #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .MASK_W(MASK_W),
    .BASE_SH_W(BASE_SH_W), .BASE_SH_N(BASE_SH_N),
    .SIZE_SH_W(SIZE_SH_W), .SIZE_SH_N(SIZE_SH_N)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .reqAddr  (reqAddr),
    .bankValid(bankValid),
    .bankBase (bankBase),
    .bankSize (bankSize),
    .hit      (hit),
    .bankIdx  (bankIdx),
    .overlap  (overlap)
  );
endmodule

// File: rtl/mbd_checker.sv
module mbd_checker
  import mbd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       reqAddr,
  input logic [BANKS-1:0]        bankValid,
  input logic [BANKS*ADDR_W-1:0] bankBase,
  input logic [BANKS*ADDR_W-1:0] bankSize,
  input logic                    hit,
  input logic [IDX_W-1:0]        bankIdx,
  input logic                    overlap
);
  logic [BANKS-1:0]        pastValid;
  logic [ADDR_W-1:0]       pastAddr;
  logic [BANKS*ADDR_W-1:0] pastBase;
  logic [BANKS*ADDR_W-1:0] pastSize;
  logic [ADDR_W-1:0]       selBase;
  logic [ADDR_W:0]         selEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pastValid <= '0;
      pastAddr  <= '0;
      pastBase  <= '0;
      pastSize  <= '0;
    end else begin
      pastValid <= bankValid;
      pastAddr  <= reqAddr;
      pastBase  <= bankBase;
      pastSize  <= bankSize;
    end
  end

  assign selBase = pastBase[bankIdx*ADDR_W +: ADDR_W];
  assign selEnd  = {1'b0, selBase} + {1'b0, pastSize[bankIdx*ADDR_W +: ADDR_W]};

  AST_OVERLAP_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rstN)
    overlap |-> hit); // R7
  AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (bankIdx == '0)); // R6
  AST_HIT_BANK_VALID: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> pastValid[bankIdx]); // R3
  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> ((pastAddr >= selBase) && ({1'b0, pastAddr} < selEnd))); // R8
endmodule

bind mem_bank_decoder mbd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqAddr  (reqAddr),
  .bankValid(bankValid),
  .bankBase (bankBase),
  .bankSize (bankSize),
  .hit      (hit),
  .bankIdx  (bankIdx),
  .overlap  (overlap)
);

// File: tb/mem_bank_decoder_tb.sv
`timescale 1ns/1ps
module mem_bank_decoder_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic         wrSel = 1'b0;
  logic [31:0]  wrData = '0;
  logic [3:0]   revId = 4'd5;
  logic [31:0]  reqAddr = '0;
  logic [3:0]   bankValid;
  logic [127:0] bankBase;
  logic [127:0] bankSize;
  logic         hit;
  logic [1:0]   bankIdx;
  logic         overlap;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mem_bank_decoder u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .revId(revId), .reqAddr(reqAddr), .bankValid(bankValid),
    .bankBase(bankBase), .bankSize(bankSize), .hit(hit),
    .bankIdx(bankIdx), .overlap(overlap)
  );

  // {rev, addr, hit, idx, overlap}
  localparam int NV = 14;
  localparam logic [39:0] VEC [NV] = '{
    {4'd5, 32'h00FF_FFFF, 1'b0, 2'd0, 1'b0},
    {4'd5, 32'h0100_0000, 1'b1, 2'd0, 1'b0},
    {4'd5, 32'h01FF_FFFF, 1'b1, 2'd0, 1'b0},
    {4'd5, 32'h0200_0000, 1'b1, 2'd1, 1'b0},
    {4'd5, 32'h0300_0000, 1'b1, 2'd1, 1'b1},
    {4'd5, 32'h03FF_FFFF, 1'b1, 2'd1, 1'b1},
    {4'd5, 32'h0400_0000, 1'b0, 2'd0, 1'b0},
    {4'd5, 32'h0800_0000, 1'b0, 2'd0, 1'b0},
    {4'd4, 32'h0040_0000, 1'b1, 2'd0, 1'b0},
    {4'd4, 32'h007F_FFFF, 1'b1, 2'd0, 1'b0},
    {4'd4, 32'h0080_0000, 1'b1, 2'd1, 1'b0},
    {4'd4, 32'h00C0_0000, 1'b1, 2'd1, 1'b1},
    {4'd4, 32'h0100_0000, 1'b0, 2'd0, 1'b0},
    {4'd6, 32'h0100_0000, 1'b1, 2'd0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  task automatic wrCfg(input logic sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // drive at a falling edge, result is registered at the next rising edge
  task automatic lookup(input logic [3:0] rev, input logic [31:0] addr);
    @(negedge clk);
    revId = rev; reqAddr = addr;
    @(negedge clk);
  endtask

  function automatic logic [31:0] slice(input logic [127:0] bus, input int b);
    return bus[b*32 +: 32];
  endfunction

  initial begin
    #200000;
    nVec++; nBad++;
    $display("FAIL watchdog: actual 0x00000000 expected 0x00000001");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", 32'(bankValid), 32'h0);
    check("R1 hit", {29'd0, hit, bankIdx}, 32'h0);
    rstN = 1'b1;
    lookup(4'd5, 32'h0100_0000);
    check("R1 after release", {28'd0, bankValid}, 32'h0);
    check("R1 no hit", {29'd0, hit, overlap, 1'b0}, 32'h0);

    // bank0 0x2001, bank1 0x2102, bank2 0x2003, bank3 0x0008 (invalid)
    wrCfg(1'b0, 32'h2001_2102);
    wrCfg(1'b1, 32'h2003_0008);
    check("R2 R3 valid map", 32'(bankValid), 32'h7);
    revId = 4'd5; #1;
    check("R2 R4 base bank0 wide", slice(bankBase, 0), 32'h0100_0000);
    check("R2 R4 base bank3 wide", slice(bankBase, 3), 32'h0800_0000);
    check("R2 R5 size bank1 wide", slice(bankSize, 1), 32'h0200_0000);
    revId = 4'd4; #1;
    check("R4 base bank2 narrow", slice(bankBase, 2), 32'h00C0_0000);
    check("R5 size bank1 narrow", slice(bankSize, 1), 32'h0080_0000);
    check("R5 size bank0 narrow", slice(bankSize, 0), 32'h0040_0000);

    // R6 R7 R3 R4: vector table
    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i][39:36], VEC[i][35:4]);
      check($sformatf("R6 R7 vector %0d", i), {28'd0, hit, bankIdx, overlap},
            {28'd0, VEC[i][3:0]});
    end

    // R9: bits 15:14 of each field ignored
    wrCfg(1'b1, 32'hE003_C008);
    revId = 4'd5; #1;
    check("R9 valid", 32'(bankValid), 32'h7);
    check("R9 base bank2", slice(bankBase, 2), 32'h0300_0000);
    check("R9 base bank3", slice(bankBase, 3), 32'h0800_0000);
    check("R9 size bank3", slice(bankSize, 3), 32'h0100_0000);

    // R6: bank3 from 0xFF000000 of size 0x20000000 must not wrap
    wrCfg(1'b1, 32'h2003_3FFF);
    lookup(4'd5, 32'h0000_0010);
    check("R6 no wrap low", {29'd0, hit, bankIdx}, 32'h0);
    lookup(4'd5, 32'hFFFF_FFFF);
    check("R6 top hit", {29'd0, hit, bankIdx}, 32'h7);
    lookup(4'd5, 32'hFEFF_FFFF);
    check("R6 below base", {29'd0, hit, bankIdx}, 32'h0);

    // R8: output changes only at the rising edge after the address
    @(negedge clk);
    reqAddr = 32'h0100_0000;
    #1;
    check("R8 before edge", {31'd0, hit}, 32'h0);
    @(negedge clk);
    check("R8 after edge", {29'd0, hit, bankIdx}, 32'h4);

    // R1: reset in mid-run clears configuration and outputs
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", {25'd0, bankValid, hit, bankIdx}, 32'h0);
    rstN = 1'b1;
    lookup(4'd5, 32'h0100_0000);
    check("R1 stays invalid", {31'd0, hit}, 32'h0);

    report();
  end
endmodule